// File: doc/BRIEF.md
# Mode-Dependent General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port. Two registers sit behind a small register bus. The direction register chooses, pin by pin, whether the pad is driven. The data register holds the value that driven pins carry. A pin whose direction bit is 1 has its output enable raised and drives the matching data bit. A pin whose direction bit is 0 is released, and its pad level can be read back through the data register address.

An operating-mode input changes two things. It sets the value the direction register returns to after reset, and it decides whether bit 6 is permanently an output. Two standby controls are also provided. Hardware standby returns both registers to their reset values and releases every pin while it is asserted. Software standby freezes the port, so pins that are being driven stay driven. Pad levels pass through a two-flop synchroniser before they reach the read path.

Top module: `gpio_mode_port`

## Requirements
- R1: A direction bit of 1 sets the pin's `pin_oe` bit high, with `pin_out` carrying the matching data-register bit. A direction bit of 0 sets `pin_oe` low.
- R2: A read with `addr` = 0, which selects the direction register, always returns 0xFF, whatever the register holds.
- R3: With `op_mode` equal to 2'd1 or 2'd2, direction bit 6 stays at 1 and writes to it are ignored. With `op_mode` equal to 2'd0 or 2'd3, bit 6 is an ordinary writable bit.
- R4: After a reset (`rst_n` low, sampled on the clock edge), the direction register holds 0x40 when `op_mode` is 2'd1 or 2'd2 and 0x00 for the other codes. All data-register bits hold 0.
- R5: While `hw_stby` is high, every `pin_oe` bit is 0, both registers are returned to their R4 reset values, and bus writes are ignored.
- R6: While `sw_stby` is high, both registers keep their contents and bus writes are ignored, so `pin_oe` and `pin_out` do not change.
- R7: A read with `addr` = 1, which selects the data register, returns the stored data bit for each bit other than bit 6 whose direction bit is 1.
- R8: For each bit whose direction bit is 0, a data-register read returns the pin level. That level comes through a two-flop synchroniser, so a change at `pin_in` first appears in the read value after the second rising clock edge.
- R9: Bit 6 of a data-register read always returns the synchronised pin level, whatever its direction bit.
- R10: `rdata` is 0 unless `cs` and `rd_en` are both high. A write needs both `cs` and `wr_en` high on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_mode | input | 2 | Operating mode code (1, 2 lock bit 6; 0, 3 do not) |
| hw_stby | input | 1 | Hardware standby: clears the registers and releases the pins |
| sw_stby | input | 1 | Software standby: holds the state and blocks writes |
| cs | input | 1 | Register chip select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 = direction register, 1 = data register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output data |

## Verification
The bench writes all zeros to the direction register in both locking modes. A design that failed to pin bit 6 would then release that pin, and one that locked it in modes 0 or 3 would refuse to clear it. Data reads use a mix of output and input bits, with bit 6 set to output while its pad differs from the stored data. This exposes a read mux that treats bit 6 like the other bits, and a direction read that returns the stored value instead of 0xFF. The bench also moves a pad between two edges and reads it after each edge, which catches a synchroniser that is one stage short or one stage long. Writes are attempted during both kinds of standby to separate "freeze" from "clear". A design that mixed up the two standby controls would either lose the driven pins or keep them.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants and helpers for the mode-dependent GPIO port.
// Assumes the mode code is 2 bits wide and that codes 1 and 2 are the locking modes.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OPM_RSVD   = 2'd0,
        OPM_EXT_A  = 2'd1,
        OPM_EXT_B  = 2'd2,
        OPM_SINGLE = 2'd3
    } op_mode_e;

    localparam logic SEL_DIR  = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    // True when the given mode code forces the locked pin to output.
    function automatic logic mode_locks(input logic [1:0] code);
        return (code == OPM_EXT_A) || (code == OPM_EXT_B);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchroniser for the pad input levels.
// Assumes pin_in is asynchronous to clk. Every stage clears on reset.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_in;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage moves the level one flop along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign pin_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_dir_reg.sv
// Module: direction register with a mode-dependent locked bit.
// Assumes the write strobe is already qualified by select, address and standby.
// Reset and hardware standby load the mode's reset pattern.
module gpio_dir_reg #(
    parameter int WIDTH    = 8,
    parameter int LOCK_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             lock,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_eff
);

    localparam logic [WIDTH-1:0] LOCK_ONE = WIDTH'(1) << LOCK_BIT;

    logic [WIDTH-1:0] lock_mask;
    logic [WIDTH-1:0] dir_q;

    // The mask of forced-output bits for the current mode.
    assign lock_mask = lock ? LOCK_ONE : '0;

    // Register update: reset pattern, or the bus write.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) dir_q <= lock_mask;
        else if (wr_stb)       dir_q <= wdata;
    end

    // The locked bit reads as output regardless of what was written.
    assign dir_eff = dir_q | lock_mask;

endmodule

// File: rtl/gpio_data_reg.sv
// Module: output data register.
// Assumes a qualified write strobe. Clears on reset and on hardware standby.
module gpio_data_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q
);

    // Register update: clear, or the bus write.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) data_q <= '0;
        else if (wr_stb)       data_q <= wdata;
    end

endmodule

// File: rtl/gpio_read_mux.sv
// Module: read-data selection for both register addresses.
// Assumes pin_sync is already synchronised. Output is zero when no read is active.
module gpio_read_mux #(
    parameter int WIDTH    = 8,
    parameter int LOCK_BIT = 6
) (
    input  logic             rd_stb,
    input  logic             sel,
    input  logic [WIDTH-1:0] dir_eff,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);

    import gpio_port_pkg::*;

    logic [WIDTH-1:0] port_view;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            if (b == LOCK_BIT) begin : g_live
                assign port_view[b] = pin_sync[b];
            end else begin : g_mix
                assign port_view[b] = dir_eff[b] ? data_q[b] : pin_sync[b];
            end
        end
    endgenerate

    // Direction address reads all ones. Data address reads the mixed port view.
    always_comb begin
        if (!rd_stb)            rdata = '0;
        else if (sel == SEL_DIR) rdata = '1;
        else                    rdata = port_view;
    end

endmodule

// File: rtl/gpio_mode_port.sv
// Module: top of the mode-dependent GPIO port.
// Assumes a single clock domain for the bus and a synchronous active-low reset.
// Pads are asynchronous and are resynchronised inside.
module gpio_mode_port #(
    parameter int WIDTH       = 8,
    parameter int LOCK_BIT    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_mode,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             cs,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out
);

    import gpio_port_pkg::*;

    logic             lock;
    logic             wr_ok;
    logic             dir_wr;
    logic             data_wr;
    logic [WIDTH-1:0] dir_eff;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pin_sync;

    // Write qualification: select, strobe, address and both standby states.
    assign lock    = mode_locks(op_mode);
    assign wr_ok   = cs && wr_en && !sw_stby && !hw_stby;
    assign dir_wr  = wr_ok && (addr == SEL_DIR);
    assign data_wr = wr_ok && (addr == SEL_DATA);

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_dir_reg #(.WIDTH(WIDTH), .LOCK_BIT(LOCK_BIT)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .lock    (lock),
        .wr_stb  (dir_wr),
        .wdata   (wdata),
        .dir_eff (dir_eff)
    );

    gpio_data_reg #(.WIDTH(WIDTH)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .wr_stb  (data_wr),
        .wdata   (wdata),
        .data_q  (data_q)
    );

    gpio_read_mux #(.WIDTH(WIDTH), .LOCK_BIT(LOCK_BIT)) u_rmux (
        .rd_stb   (cs && rd_en),
        .sel      (addr),
        .dir_eff  (dir_eff),
        .data_q   (data_q),
        .pin_sync (pin_sync),
        .rdata    (rdata)
    );

    // Pad controls: hardware standby releases every pin.
    assign pin_oe  = hw_stby ? '0 : dir_eff;
    assign pin_out = data_q;

endmodule

// File: rtl/gpio_mode_port_chk.sv
// Module: assertion checker for gpio_mode_port, attached by bind.
// Assumes it observes only the top-level ports.
module gpio_mode_port_chk #(
    parameter int WIDTH    = 8,
    parameter int LOCK_BIT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_mode,
    input logic             hw_stby,
    input logic             sw_stby,
    input logic             cs,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_out
);

    localparam logic [WIDTH-1:0] LOCK_ONE = WIDTH'(1) << LOCK_BIT;

    // R2
    dir_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_en && !addr) |-> (rdata == '1));

    // R3
    locked_bit_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_mode == 2'd1 || op_mode == 2'd2) && !hw_stby) |-> pin_oe[LOCK_BIT]);

    // R5
    hw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> (pin_oe == '0));

    // R5
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pin_out == '0));

    // R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(pin_out));

    // R1
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr && !sw_stby && !hw_stby) |=> (pin_out == $past(wdata)));

    // R7
    out_bits_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_en && addr && !hw_stby) |-> (((rdata ^ pin_out) & pin_oe & ~LOCK_ONE) == '0));

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en) |-> (rdata == '0));

endmodule

bind gpio_mode_port gpio_mode_port_chk #(.WIDTH(WIDTH), .LOCK_BIT(LOCK_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_mode (op_mode),
    .hw_stby (hw_stby),
    .sw_stby (sw_stby),
    .cs      (cs),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
);

// File: tb/gpio_mode_port_bench.sv
// Directed bench for gpio_mode_port: one task per scenario, each checking its own results.
module gpio_mode_port_bench;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] op_mode = 2'd3;
    logic       hw_stby = 0;
    logic       sw_stby = 0;
    logic       cs = 0;
    logic       wr_en = 0;
    logic       rd_en = 0;
    logic       addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [7:0] pin_in = 0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_mode_port u_gpio_mode_port (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .cs(cs), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        op_mode = m; rst_n = 0; hw_stby = 0; sw_stby = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr_en = 1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cs = 0; wr_en = 0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        cs = 1; rd_en = 1; addr = a;
        #1 d = rdata;
        cs = 0; rd_en = 0;
    endtask

    task automatic settle_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset(2'd3);
        check("R4 oe mode3", pin_oe, 8'h00);
        check("R4 data", pin_out, 8'h00);
        bus_rd(1'b0, v);
        check("R2 dir read", v, 8'hFF);
        do_reset(2'd1);
        check("R4 oe mode1", pin_oe, 8'h40);
    endtask

    task automatic t_mixed();
        logic [7:0] v;
        do_reset(2'd3);
        settle_pins(8'h3C);
        bus_wr(1'b0, 8'h0F);
        bus_wr(1'b1, 8'hA5);
        check("R1 oe", pin_oe, 8'h0F);
        check("R1 out", pin_out, 8'hA5);
        bus_rd(1'b1, v);
        check("R7 R8 mixed read", v, 8'h35);
        bus_rd(1'b0, v);
        check("R2 dir read after write", v, 8'hFF);
    endtask

    task automatic t_bit6();
        logic [7:0] v;
        do_reset(2'd3);
        bus_wr(1'b0, 8'hFF);
        bus_wr(1'b1, 8'h00);
        settle_pins(8'h40);
        bus_rd(1'b1, v);
        check("R9 bit6 live high", v, 8'h40);
        settle_pins(8'h00);
        bus_wr(1'b1, 8'h40);
        bus_rd(1'b1, v);
        check("R9 bit6 live low", v, 8'h00);
    endtask

    task automatic t_lock();
        do_reset(2'd2);
        bus_wr(1'b0, 8'h00);
        check("R3 locked mode2", pin_oe, 8'h40);
        do_reset(2'd1);
        bus_wr(1'b0, 8'h01);
        check("R3 locked mode1", pin_oe, 8'h41);
        do_reset(2'd0);
        bus_wr(1'b0, 8'h40);
        bus_wr(1'b0, 8'h00);
        check("R3 free mode0", pin_oe, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        do_reset(2'd3);
        settle_pins(8'h00);
        @(negedge clk);
        pin_in = 8'h81;
        @(posedge clk);
        bus_rd(1'b1, v);
        check("R8 one edge old", v, 8'h00);
        @(posedge clk);
        bus_rd(1'b1, v);
        check("R8 two edges new", v, 8'h81);
    endtask

    task automatic t_sw();
        do_reset(2'd3);
        bus_wr(1'b0, 8'hF0);
        bus_wr(1'b1, 8'h5A);
        @(negedge clk);
        sw_stby = 1;
        bus_wr(1'b1, 8'hFF);
        bus_wr(1'b0, 8'h00);
        check("R6 oe held", pin_oe, 8'hF0);
        check("R6 data held", pin_out, 8'h5A);
        @(negedge clk);
        sw_stby = 0;
        @(negedge clk);
        check("R6 oe after", pin_oe, 8'hF0);
    endtask

    task automatic t_hw();
        do_reset(2'd1);
        bus_wr(1'b0, 8'hFF);
        bus_wr(1'b1, 8'hFF);
        @(negedge clk);
        hw_stby = 1;
        #1 check("R5 oe released", pin_oe, 8'h00);
        bus_wr(1'b1, 8'h33);
        @(negedge clk);
        hw_stby = 0;
        @(negedge clk);
        check("R5 dir back to reset", pin_oe, 8'h40);
        check("R5 data cleared", pin_out, 8'h00);
    endtask

    task automatic t_bus();
        do_reset(2'd3);
        @(negedge clk);
        cs = 1; addr = 1'b0; rd_en = 0;
        #1 check("R10 no rd_en", rdata, 8'h00);
        cs = 0; rd_en = 1;
        #1 check("R10 no cs", rdata, 8'h00);
        rd_en = 0; wr_en = 1; addr = 1'b1; wdata = 8'hC3;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
        check("R10 write without cs", pin_out, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_mixed();
        t_bit6();
        t_lock();
        t_sync();
        t_sw();
        t_hw();
        t_bus();
        finish_run();
    end

endmodule